// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block sends bytes from the device end of a PS/2 link. It owns both the clock line and the data line. Each line is open-drain: the block either pulls the line low or releases it to float high. One byte goes out as an eleven-bit frame. Each bit follows a fixed, asymmetric phase pattern, built from a parameterised count of clock cycles per microsecond:

- data is presented while the clock is still released (10 us);
- the clock is then pulled low (38 us);
- the clock is released again (22 us).

At the end of every bit the block samples the real clock line through a two-flop synchronizer. A low reading means the host is holding the clock down to inhibit the device. In that case the frame is abandoned, both lines are released, and the block reports a failure.

A client raises a one-cycle start strobe with the byte to send. It then waits for a one-cycle done strobe, which comes with a fail flag. A start strobe that arrives while a frame is in flight is ignored.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset both pull outputs are 0 (lines released), and busy, done and fail are all 0. A pull output of 1 means the line is driven low.
- R2: A frame puts eleven bit values on the data line. Each value is read as the inverse of the data pull output while the clock pull is asserted. The order is: start 0, the eight byte bits LSB first, an odd parity bit (so the nine data-plus-parity bits hold an odd number of ones), and stop 1.
- R3: A new data level is presented exactly SETUP_US*CYC_PER_US cycles before the clock pull asserts. The data pull never changes while the clock pull is asserted, or in the cycle in which it releases.
- R4: The clock pull stays asserted for exactly LOW_US*CYC_PER_US cycles in every bit.
- R5: Successive clock-pull assertions within one frame are spaced by exactly (SETUP_US+LOW_US+HIGH_US)*CYC_PER_US+2 cycles, whatever the bit values.
- R6: If the synchronized clock line reads low at the end of a bit, the frame stops after that bit. Both pulls are 0 when done pulses, fail is 1, and no further clock pulses follow.
- R7: A host inhibit that ends before the end-of-bit sample point does not fail the frame.
- R8: A start strobe while busy is 1 is ignored: the frame in flight and its bits are unchanged, and no second frame follows.
- R9: Done is a single-cycle pulse, one per frame. Busy falls in the same cycle that done rises. Fail is 0 with done after all eleven bits succeed, and it holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | One-cycle request to send tx_byte |
| tx_byte | input | 8 | Byte to send |
| ps2_clk_in | input | 1 | Raw level read back from the clock line |
| clk_pull | output | 1 | 1 drives the clock line low, 0 releases it |
| dat_pull | output | 1 | 1 drives the data line low, 0 releases it |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame or an abort |
| fail | output | 1 | Set with done when the host inhibited the bus |

## Verification
Several properties are checked on every cycle:
- the data pull never changes while the clock pull is held or is just releasing;
- every clock-low phase has the exact parameterised width;
- done lasts one cycle and coincides with busy falling;
- an aborted frame leaves both lines released;
- no clock pulse happens while idle.

Other behaviours only the bench scenarios can show: the frame content and parity, the exact bit spacing for mixed 0/1 patterns, the setup lead of data before the clock, and the difference between an inhibit held through the sample point and one released before it. The same holds for a start strobe ignored mid-frame.

// File: rtl/ps2_tx_pkg.sv
// Shared types and constants for the PS/2 device-side transmitter.
// Assumes one frame is always start + 8 data + parity + stop.
package ps2_tx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_WAIT = 1'b1
    } frame_st_t;
endpackage

// File: rtl/ps2_line_sync.sv
// Multi-stage synchronizer for an asynchronous line level.
// Assumes STAGES >= 2; the reset value is the released (high) line.
module ps2_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
        end
    end

    assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/ps2_bit_engine.sv
// Sends one bit: data is presented with the clock released, then the clock is
// held low, then released again. At the end of the bit the synchronized clock
// level is stored as the success flag. Both pulls live in registers, so a
// change to the clock never disturbs the data level already presented.
// Assumes go arrives only while idle, and release only while idle.
module ps2_bit_engine
    import ps2_tx_pkg::*;
#(
    parameter int SETUP_CYC = 20,
    parameter int LOW_CYC   = 76,
    parameter int HIGH_CYC  = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bit_val,
    input  logic release_lines,
    input  logic clk_sync,
    output logic clk_pull,
    output logic dat_pull,
    output logic bit_done,
    output logic bit_ok
);
    localparam int MAX_A = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
    localparam int MAX_C = (MAX_A > HIGH_CYC) ? MAX_A : HIGH_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    phase_t          phase;
    logic [CW-1:0]   cnt;

    // Phase sequencer: one down-counter times each phase in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            clk_pull <= 1'b0;
            dat_pull <= 1'b0;
            bit_done <= 1'b0;
            bit_ok   <= 1'b0;
        end else begin
            bit_done <= 1'b0;
            if (release_lines) begin
                clk_pull <= 1'b0;
                dat_pull <= 1'b0;
                phase    <= PH_IDLE;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (go) begin
                            dat_pull <= ~bit_val;
                            cnt      <= CW'(SETUP_CYC - 1);
                            phase    <= PH_SETUP;
                        end
                    end
                    PH_SETUP: begin
                        if (cnt == '0) begin
                            clk_pull <= 1'b1;
                            cnt      <= CW'(LOW_CYC - 1);
                            phase    <= PH_LOW;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_LOW: begin
                        if (cnt == '0) begin
                            clk_pull <= 1'b0;
                            cnt      <= CW'(HIGH_CYC - 1);
                            phase    <= PH_HIGH;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (cnt == '0) begin
                            bit_done <= 1'b1;
                            bit_ok   <= clk_sync;
                            phase    <= PH_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ps2_frame_seq.sv
// Frame sequencer: builds the eleven-bit frame (start, data LSB first, odd
// parity, stop), issues one go pulse per bit, and aborts on a failed bit by
// asking the bit engine to release both lines.
// Assumes the bit engine answers every go with exactly one bit_done.
module ps2_frame_seq
    import ps2_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       bit_done,
    input  logic       bit_ok,
    output logic       go,
    output logic       bit_val,
    output logic       release_lines,
    output logic       busy,
    output logic       done,
    output logic       fail
);
    frame_st_t               st;
    logic [FRAME_BITS-1:0]   frame_bits;
    logic [IDX_W-1:0]        idx;

    // Current bit to present and the abort request to the engine.
    always_comb begin
        bit_val       = frame_bits[idx];
        release_lines = (st == FR_WAIT) && bit_done && !bit_ok;
    end

    // Frame control: accept a start, step bits, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FR_IDLE;
            frame_bits <= '1;
            idx        <= '0;
            go         <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            fail       <= 1'b0;
        end else begin
            done <= 1'b0;
            go   <= 1'b0;
            case (st)
                FR_IDLE: begin
                    if (start) begin
                        frame_bits <= {1'b1, ~^byte_in, byte_in, 1'b0};
                        idx        <= '0;
                        go         <= 1'b1;
                        busy       <= 1'b1;
                        fail       <= 1'b0;
                        st         <= FR_WAIT;
                    end
                end
                FR_WAIT: begin
                    if (bit_done) begin
                        if (!bit_ok) begin
                            done <= 1'b1;
                            fail <= 1'b1;
                            busy <= 1'b0;
                            st   <= FR_IDLE;
                        end else if (idx == IDX_W'(FRAME_BITS - 1)) begin
                            done <= 1'b1;
                            busy <= 1'b0;
                            st   <= FR_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            go  <= 1'b1;
                        end
                    end
                end
                default: st <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_dev_tx.sv
// Top of the PS/2 device-side transmitter. Connects the line synchronizer,
// the per-bit phase engine and the frame sequencer. Phase lengths come from
// microsecond parameters scaled by CYC_PER_US.
// Assumes ps2_clk_in is the real (wired) clock line level.
module ps2_dev_tx #(
    parameter int CYC_PER_US  = 125,
    parameter int SETUP_US    = 10,
    parameter int LOW_US      = 38,
    parameter int HIGH_US     = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_start,
    input  logic [7:0] tx_byte,
    input  logic       ps2_clk_in,
    output logic       clk_pull,
    output logic       dat_pull,
    output logic       busy,
    output logic       done,
    output logic       fail
);
    localparam int SETUP_CYC = SETUP_US * CYC_PER_US;
    localparam int LOW_CYC   = LOW_US * CYC_PER_US;
    localparam int HIGH_CYC  = HIGH_US * CYC_PER_US;

    logic clk_sync;
    logic go;
    logic bit_val;
    logic release_lines;
    logic bit_done;
    logic bit_ok;

    ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (ps2_clk_in),
        .line_sync (clk_sync)
    );

    ps2_bit_engine #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (LOW_CYC),
        .HIGH_CYC  (HIGH_CYC)
    ) u_bit (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .bit_val       (bit_val),
        .release_lines (release_lines),
        .clk_sync      (clk_sync),
        .clk_pull      (clk_pull),
        .dat_pull      (dat_pull),
        .bit_done      (bit_done),
        .bit_ok        (bit_ok)
    );

    ps2_frame_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (tx_start),
        .byte_in       (tx_byte),
        .bit_done      (bit_done),
        .bit_ok        (bit_ok),
        .go            (go),
        .bit_val       (bit_val),
        .release_lines (release_lines),
        .busy          (busy),
        .done          (done),
        .fail          (fail)
    );
endmodule

// File: rtl/ps2_dev_tx_chk.sv
// Checker for ps2_dev_tx: line ordering, clock-low width, done/busy
// handshake and abort release. Bound to every ps2_dev_tx instance.
module ps2_dev_tx_chk #(
    parameter int LOW_CYC = 76
) (
    input logic clk,
    input logic rst_n,
    input logic clk_pull,
    input logic dat_pull,
    input logic busy,
    input logic done,
    input logic fail
);
    int unsigned low_cnt;

    // Count cycles the clock pull has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) low_cnt <= 0;
        else if (clk_pull) low_cnt <= low_cnt + 1;
        else low_cnt <= 0;
    end

    assert_dat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dat_pull) |-> (!clk_pull && !$past(clk_pull)));

    assert_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_pull) |-> (low_cnt == LOW_CYC));

    assert_abort_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (!clk_pull && !dat_pull));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !clk_pull);
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.LOW_CYC(LOW_US * CYC_PER_US)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_pull (clk_pull),
    .dat_pull (dat_pull),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
);

// File: tb/ps2_dev_tx_bench.sv
// Bench for ps2_dev_tx: random and directed frames, inhibit abort, momentary
// inhibit, and start strobes while busy.
module ps2_dev_tx_bench;
    localparam int CPU    = 2;
    localparam int S_CYC  = 10 * CPU;
    localparam int L_CYC  = 38 * CPU;
    localparam int H_CYC  = 22 * CPU;
    localparam int PERIOD = S_CYC + L_CYC + H_CYC + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       host_inh = 1'b0;
    logic       clk_pull, dat_pull, busy, done, fail;
    logic       line_clk;

    assign line_clk = !clk_pull && !host_inh;

    ps2_dev_tx #(.CYC_PER_US(CPU)) u_ps2_dev_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start   (tx_start),
        .tx_byte    (tx_byte),
        .ps2_clk_in (line_clk),
        .clk_pull   (clk_pull),
        .dat_pull   (dat_pull),
        .busy       (busy),
        .done       (done),
        .fail       (fail)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int pulses = 0;
    int dones  = 0;
    int rise_t = -1;
    int datchg_t = -1;
    logic cap [0:15];
    logic prev_clk = 1'b0;
    logic prev_dat = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, ~^b, b, 1'b0};
    endfunction

    // Line monitor: timing of every bit, sampled on the falling clock edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dat_pull !== prev_dat) datchg_t = cyc;
            if (clk_pull && !prev_clk) begin
                if (pulses > 0)
                    check(cyc - rise_t == PERIOD, "R5 bit spacing", cyc - rise_t, PERIOD);
                if (datchg_t == cyc - S_CYC || pulses > 0)
                    check(pulses == 0 ? (cyc - datchg_t == S_CYC) : (cyc - datchg_t >= S_CYC),
                          "R3 data lead", cyc - datchg_t, S_CYC);
                else
                    check(1'b0, "R3 first data lead", cyc - datchg_t, S_CYC);
                rise_t = cyc;
                if (pulses < 16) cap[pulses] = ~dat_pull;
                pulses++;
            end
            if (!clk_pull && prev_clk)
                check(cyc - rise_t == L_CYC, "R4 low width", cyc - rise_t, L_CYC);
            if (done) dones++;
        end
        prev_clk = clk_pull;
        prev_dat = dat_pull;
    end

    // Send one frame; inh_bit >= 0 inhibits during that bit's low phase,
    // momentary releases it at the clock release; extra_start pulses start mid-frame.
    task automatic send_frame(input logic [7:0] b, input int inh_bit,
                              input bit momentary, input bit extra_start);
        int wait_c;
        int d0;
        bit got;
        bit extra_done;
        logic [10:0] ef;
        ef = exp_frame(b);
        @(negedge clk);
        pulses = 0;
        datchg_t = -1;
        d0 = dones;
        tx_byte = b;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        got = 1'b0;
        extra_done = 1'b0;
        wait_c = 0;
        while (!got && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
            if (extra_start && !extra_done && pulses == 3) begin
                tx_byte = ~b;
                tx_start = 1'b1;
                extra_done = 1'b1;
            end else begin
                tx_start = 1'b0;
                tx_byte = b;
            end
            if (inh_bit >= 0 && pulses == inh_bit + 1 && clk_pull && !host_inh && !momentary)
                host_inh = 1'b1;
            if (momentary && inh_bit >= 0 && pulses == inh_bit + 1 && clk_pull)
                host_inh = 1'b1;
            if (momentary && host_inh && !clk_pull)
                host_inh = 1'b0;
            if (done) got = 1'b1;
        end
        tx_start = 1'b0;
        if (!got) begin
            check(1'b0, "R9 done timeout", 0, 1);
            return;
        end
        check(busy == 1'b0, "R9 busy falls with done", busy, 0);
        if (inh_bit >= 0 && !momentary) begin
            check(fail == 1'b1, "R6 fail flag", fail, 1);
            check(pulses == inh_bit + 1, "R6 pulse count", pulses, inh_bit + 1);
            check(!clk_pull && !dat_pull, "R6 lines released", {clk_pull, dat_pull}, 0);
        end else begin
            check(fail == 1'b0, momentary ? "R7 no fail" : "R9 fail low", fail, 0);
            check(pulses == 11, "R2 bit count", pulses, 11);
            for (int i = 0; i < 11; i++)
                check(cap[i] == ef[i], extra_start ? "R8 frame bits" : "R2 frame bit",
                      cap[i], ef[i]);
        end
        host_inh = 1'b0;
        repeat (3 * PERIOD) @(negedge clk);
        check(dones - d0 == 1, "R9 one done", dones - d0, 1);
        check(fail == ((inh_bit >= 0 && !momentary) ? 1'b1 : 1'b0), "R9 fail held",
              fail, (inh_bit >= 0 && !momentary) ? 1 : 0);
        check(busy == 1'b0 && !clk_pull, extra_start ? "R8 no second frame" : "R6 quiet after",
              busy, 0);
        if (inh_bit >= 0 && !momentary)
            check(pulses == inh_bit + 1, "R6 no further pulses", pulses, inh_bit + 1);
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1207);
        repeat (4) @(negedge clk);
        check(!clk_pull && !dat_pull, "R1 lines released in reset", {clk_pull, dat_pull}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
        check(!clk_pull && !dat_pull, "R1 lines after reset", {clk_pull, dat_pull}, 0);

        send_frame(8'h00, -1, 1'b0, 1'b0);
        send_frame(8'hFF, -1, 1'b0, 1'b0);
        send_frame(8'hA5, -1, 1'b0, 1'b0);
        for (int n = 0; n < 5; n++)
            send_frame(8'($urandom), -1, 1'b0, 1'b0);
        send_frame(8'h3C, 4, 1'b0, 1'b0);
        send_frame(8'h81, 0, 1'b0, 1'b0);
        send_frame(8'h7E, 10, 1'b0, 1'b0);
        send_frame(8'h5A, 6, 1'b1, 1'b0);
        send_frame(8'($urandom), 2, 1'b1, 1'b0);
        send_frame(8'hC3, -1, 1'b0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule